// File: doc/BRIEF.md
# Token-Based Bandwidth Allocation Manager

This block meters how often groups of requesters may issue commands to a set of shared resources, such as memory banks and the inbound and outbound sides of I/O links. Software places each requester in an allocation group and programs a token period for every group and resource pair. A counter for each pair deposits a token when it expires. A requester may use a resource only in a cycle in which its group holds a token for it, or can borrow a token that another group is not using. Each grant consumes one token.

Requesters present a request together with a resource index and hold it until they are granted. The grant is combinational in the same cycle. Within a group, requesters aiming at the same resource take turns. A resource that reports congestion stops its token counters. A requester that waits too long raises an over-commit interrupt. With the facility switched off, every request passes through at once.

Top module: `tbm_manager`

## Requirements
- R1: With enable set, a pair whose period P is nonzero and whose resource is not congested gains a token every P cycles. After a write of P to the pair, the first token can be granted P+1 cycles later, and then every P cycles while requests keep arriving. With a period of 0, the pair never produces a token.
- R2: A pair holds at most one token. Tokens produced while one is already held are lost.
- R3: While congest[k] is high, every token counter for resource k is frozen. Its count resumes from the frozen value when congestion clears.
- R4: With enable set, a request is granted in the same cycle only if its group holds a token for the requested resource, or borrows one. The grant consumes that token at the next clock edge.
- R5: In any cycle, at most one requester of a group is granted on a given resource. Members of the same group that want the same resource are served in rotating order, starting after the last one granted.
- R6: A group that holds a token for a resource but has no request for it this cycle may lend that token. At most one loan is made per resource per cycle. The lowest-numbered group that is requesting without a token receives it, and the lowest-numbered spare group supplies it.
- R7: A group that is requesting a resource never lends its own token for that resource.
- R8: With enable clear, grant equals req_valid in every cycle, and no tokens are consumed.
- R9: Each requester counts the consecutive cycles in which it was enabled, requesting and not granted. The count clears on a grant or when the request drops. overcommit_irq is high while any count is at least the nonzero threshold. A threshold of 0 disables the interrupt.
- R10: A write uses cfg_addr = {kind[1:0], index}. Kind 0 sets enable from cfg_wdata[0]. Kind 1 sets the wait threshold. Kind 2 sets the group of requester `index`. Kind 3 sets the period of pair `index` = group*N_RES + resource. Writes to an index that is out of range are ignored.
- R11: After reset, enable is clear, all periods, group assignments and the threshold are 0, no tokens are held, and overcommit_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Write address {kind, index} |
| cfg_wdata | input | 8 | Write data |
| req_valid | input | 17 | Request from each requester |
| req_res | input | 85 | Resource index of each requester, 5 bits each |
| congest | input | 20 | Congestion feedback, one bit per resource |
| grant | output | 17 | Grant to each requester |
| overcommit_irq | output | 1 | Over-commit warning interrupt |

## Verification
The assertions assume that a requester holds its resource index steady while it requests. They also assume that register writes never collide with the cycle in which a new period should take effect for a pair under test. The stimulus changes req_res only while the matching req_valid bits are low, and issues every write on its own between sampled windows. The checks also rely on req_res naming a resource below N_RES. The bench drains tokens before each scenario by writing a period of 0 while a request is still pending, so that no scenario starts with a stale token.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  // Rotating pick: first set bit of mask at or after ptr, wrapping at n.
  function automatic logic [31:0] rr_pick(input logic [31:0] mask,
                                          input int unsigned n,
                                          input int unsigned ptr);
    logic [31:0] r;
    int unsigned idx;
    r = '0;
    for (int unsigned i = 0; i < n; i++) begin
      idx = (ptr + i) % n;
      if (r == '0 && mask[idx]) r[idx] = 1'b1;
    end
    return r;
  endfunction

  // Index of the set bit of a one-hot vector.
  function automatic int unsigned oh_index(input logic [31:0] v);
    int unsigned k;
    k = 0;
    for (int unsigned i = 0; i < 32; i++) if (v[i]) k = i;
    return k;
  endfunction

  // Isolate the lowest set bit.
  function automatic logic [31:0] lowest_set(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/tbm_token_cell.sv
module tbm_token_cell #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] period,
  input  logic              load,
  input  logic [RATE_W-1:0] load_val,
  input  logic              cong,
  input  logic              consume,
  output logic              tok
);
  logic [RATE_W-1:0] cnt;
  logic              deposit;

  assign deposit = (period != '0) && !cong && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tok <= 1'b0;
    end else begin
      if (load)
        cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
      else if (period != '0 && !cong)
        cnt <= (cnt == '0) ? period - 1'b1 : cnt - 1'b1;
      tok <= (tok & ~consume) | deposit;
    end
  end

  AST_CONSUME_HELD: assert property (@(posedge clk) disable iff (!rst_n) consume |-> tok); // R4
  AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (period == '0 && !load) |=> !$rose(tok)); // R1
  AST_CONGEST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (cong && !load) |=> !$rose(tok)); // R3

endmodule

// File: rtl/tbm_res_arb.sv
module tbm_res_arb
  import tbm_pkg::*;
#(
  parameter int unsigned N_REQ = 17,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned GRP_W = 2,
  parameter int unsigned REQ_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [N_REQ-1:0]       want,
  input  logic [N_REQ*GRP_W-1:0] grp_flat,
  input  logic [N_GRP-1:0]       tok,
  output logic [N_REQ-1:0]       gnt,
  output logic [N_GRP-1:0]       consume
);
  logic [N_REQ-1:0] member [N_GRP];
  logic [31:0]      pick   [N_GRP];
  logic [REQ_W-1:0] ptr    [N_GRP];
  logic [N_GRP-1:0] demand, needy, spare, served, borrower, lender;
  logic [31:0]      low_needy, low_spare;

  always_comb begin
    for (int g = 0; g < N_GRP; g++) begin
      for (int r = 0; r < N_REQ; r++)
        member[g][r] = want[r] && (grp_flat[r*GRP_W +: GRP_W] == GRP_W'(g));
      demand[g] = |member[g];
      pick[g]   = rr_pick(32'(member[g]), N_REQ, 32'(ptr[g]));
    end
  end

  assign needy     = demand & ~tok;
  assign spare     = tok & ~demand;
  assign low_needy = lowest_set(32'(needy));
  assign low_spare = lowest_set(32'(spare));
  assign borrower  = (spare != '0) ? low_needy[N_GRP-1:0] : '0;
  assign lender    = (needy != '0) ? low_spare[N_GRP-1:0] : '0;
  assign served    = demand & (tok | borrower);
  assign consume   = en ? ((demand & tok) | lender) : '0;

  always_comb begin
    gnt = '0;
    for (int g = 0; g < N_GRP; g++)
      if (served[g]) gnt = gnt | pick[g][N_REQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < N_GRP; g++) ptr[g] <= '0;
    end else if (en) begin
      for (int g = 0; g < N_GRP; g++)
        if (served[g]) ptr[g] <= REQ_W'((oh_index(pick[g]) + 1) % N_REQ);
    end
  end

  AST_BORROW_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) $countones(lender) == $countones(borrower)); // R6
  AST_OWN_NOT_LENT: assert property (@(posedge clk) disable iff (!rst_n) (lender & demand) == '0); // R7

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
    AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n) $countones(gnt & member[g]) <= 1); // R5
  end

endmodule

// File: rtl/tbm_wait_mon.sv
module tbm_wait_mon #(
  parameter int unsigned N_REQ  = 17,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [N_REQ-1:0]  req,
  input  logic [N_REQ-1:0]  gnt,
  input  logic [WAIT_W-1:0] thr,
  output logic              irq
);
  logic [WAIT_W-1:0] waitc [N_REQ];
  logic [N_REQ-1:0]  over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_REQ; r++) waitc[r] <= '0;
    end else begin
      for (int r = 0; r < N_REQ; r++) begin
        if (en && req[r] && !gnt[r])
          waitc[r] <= (waitc[r] == '1) ? waitc[r] : waitc[r] + 1'b1;
        else
          waitc[r] <= '0;
      end
    end
  end

  always_comb
    for (int r = 0; r < N_REQ; r++) over[r] = (thr != '0) && (waitc[r] >= thr);

  assign irq = |over;

  AST_IRQ_AFTER_DENIAL: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(en && |(req & ~gnt))); // R9

endmodule

// File: rtl/tbm_manager.sv
module tbm_manager #(
  parameter int unsigned N_REQ  = 17,
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned N_RES  = 20,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned WAIT_W = 8,
  localparam int unsigned GRP_W  = $clog2(N_GRP),
  localparam int unsigned RES_W  = $clog2(N_RES),
  localparam int unsigned REQ_W  = $clog2(N_REQ),
  localparam int unsigned PAIRS  = N_GRP * N_RES,
  localparam int unsigned IDX_W  = $clog2((N_REQ > PAIRS) ? N_REQ : PAIRS),
  localparam int unsigned ADDR_W = IDX_W + 2,
  localparam int unsigned DW0    = (RATE_W > WAIT_W) ? RATE_W : WAIT_W,
  localparam int unsigned DATA_W = (DW0 > GRP_W) ? DW0 : GRP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ*RES_W-1:0] req_res,
  input  logic [N_RES-1:0]       congest,
  output logic [N_REQ-1:0]       grant,
  output logic                   overcommit_irq
);
  logic [1:0]             kind;
  logic [IDX_W-1:0]       idx;
  logic                   en_q;
  logic [WAIT_W-1:0]      thr_q;
  logic [N_REQ*GRP_W-1:0] grp_q;
  logic [RATE_W-1:0]      per_q  [PAIRS];
  logic [PAIRS-1:0]       load_p;
  logic                   tok_p  [PAIRS];
  logic [N_GRP-1:0]       tok_k  [N_RES];
  logic [N_GRP-1:0]       cons_k [N_RES];
  logic [N_REQ-1:0]       want_k [N_RES];
  logic [N_REQ-1:0]       gnt_k  [N_RES];
  logic [N_REQ-1:0]       gnt_any;

  assign kind = cfg_addr[ADDR_W-1 -: 2];
  assign idx  = cfg_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      grp_q <= '0;
    end else if (cfg_we) begin
      case (kind)
        2'd0: en_q <= cfg_wdata[0];
        2'd1: thr_q <= cfg_wdata[WAIT_W-1:0];
        2'd2: if (32'(idx) < N_REQ) grp_q[int'(idx)*GRP_W +: GRP_W] <= cfg_wdata[GRP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb
    for (int p = 0; p < PAIRS; p++) load_p[p] = cfg_we && (kind == 2'd3) && (idx == IDX_W'(p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAIRS; p++) per_q[p] <= '0;
    end else begin
      for (int p = 0; p < PAIRS; p++)
        if (load_p[p]) per_q[p] <= cfg_wdata[RATE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar k = 0; k < N_RES; k++) begin : g_res
      localparam int unsigned P = g * N_RES + k;
      tbm_token_cell #(.RATE_W(RATE_W)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (per_q[P]),
        .load     (load_p[P]),
        .load_val (cfg_wdata[RATE_W-1:0]),
        .cong     (congest[k]),
        .consume  (cons_k[k][g]),
        .tok      (tok_p[P])
      );
    end
  end

  always_comb begin
    for (int k = 0; k < N_RES; k++) begin
      for (int g = 0; g < N_GRP; g++) tok_k[k][g] = tok_p[g*N_RES + k];
      for (int r = 0; r < N_REQ; r++)
        want_k[k][r] = req_valid[r] && (req_res[r*RES_W +: RES_W] == RES_W'(k));
    end
  end

  for (genvar k = 0; k < N_RES; k++) begin : g_arb
    tbm_res_arb #(.N_REQ(N_REQ), .N_GRP(N_GRP), .GRP_W(GRP_W), .REQ_W(REQ_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .want     (want_k[k]),
      .grp_flat (grp_q),
      .tok      (tok_k[k]),
      .gnt      (gnt_k[k]),
      .consume  (cons_k[k])
    );
  end

  always_comb begin
    gnt_any = '0;
    for (int k = 0; k < N_RES; k++) gnt_any = gnt_any | gnt_k[k];
  end

  assign grant = en_q ? gnt_any : req_valid;

  tbm_wait_mon #(.N_REQ(N_REQ), .WAIT_W(WAIT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .req   (req_valid),
    .gnt   (grant),
    .thr   (thr_q),
    .irq   (overcommit_irq)
  );

  AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> (grant == req_valid && !overcommit_irq)); // R8
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req_valid) == '0); // R4

endmodule

// File: tb/tbm_manager_bench.sv
module tbm_manager_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] req_valid = '0;
  logic [3:0] req_res = '0;
  logic [1:0] congest = '0;
  logic [3:0] grant;
  logic       overcommit_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbm_manager #(.N_REQ(4), .N_GRP(3), .N_RES(2), .RATE_W(4), .WAIT_W(4)) u_tbm_manager (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_res(req_res), .congest(congest),
    .grant(grant), .overcommit_irq(overcommit_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10 address layout: {kind[1:0], index[2:0]}; returns at the negedge after the write edge
  task automatic wr(input int kind, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {kind[1:0], idx[2:0]};
    cfg_wdata = val[3:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset: disabled, so requests pass; no interrupt
    req_valid = 4'hF;
    #1;
    chk("R11 reset irq", 32'(overcommit_irq), 0);
    chk("R11 reset bypass grant", 32'(grant), 32'hF);
    req_valid = '0;

    wr(0, 0, 1);          // enable
    wr(2, 0, 0); wr(2, 1, 0); wr(2, 2, 1); wr(2, 3, 2);

    // R1 period 0 gives nothing; R9 threshold 0 keeps irq low
    req_valid = 4'b0001; req_res = 4'b0000;
    for (int j = 0; j < 10; j++) begin
      if (j > 0) @(negedge clk);
      #1;
      chk("R1 zero period grant", 32'(grant), 0);
      chk("R9 zero threshold irq", 32'(overcommit_irq), 0);
    end
    req_valid = '0;

    // R1 rate sweep over every period
    for (int p = 1; p <= 15; p++) begin
      wr(3, 0, p);
      req_valid = 4'b0001;
      for (int j = 1; j <= 3 * p + 1; j++) begin
        if (j > 1) @(negedge clk);
        #1;
        chk($sformatf("R1 period %0d sample %0d", p, j), 32'(grant[0]), 32'(j > 1 && ((j - 1) % p) == 0));
      end
      wr(3, 0, 0);
      req_valid = '0;
    end

    // R2 saturation at one token
    wr(3, 0, 3);
    for (int j = 1; j <= 16; j++) begin
      if (j > 1) @(negedge clk);
      if (j == 14) req_valid = 4'b0001;
      #1;
      if (j >= 14) chk($sformatf("R2 saturate sample %0d", j), 32'(grant[0]), 32'(j != 15));
    end
    wr(3, 0, 0);
    req_valid = '0;

    // R3 congestion freezes the counter
    wr(3, 0, 2);
    req_valid = 4'b0001; congest = 2'b01;
    for (int j = 1; j <= 13; j++) begin
      if (j > 1) @(negedge clk);
      if (j == 11) congest = 2'b00;
      #1;
      chk($sformatf("R3 congest sample %0d", j), 32'(grant[0]), 32'(j == 13));
    end
    wr(3, 0, 0);
    req_valid = '0;

    // R5 rotation between r0 and r1 of group 0 (last winner r0)
    wr(3, 0, 1);
    req_valid = 4'b0011;
    for (int j = 1; j <= 9; j++) begin
      if (j > 1) @(negedge clk);
      #1;
      chk($sformatf("R5 rotate sample %0d", j), 32'(grant), (j == 1) ? 0 : ((j % 2 == 0) ? 2 : 1));
    end
    wr(3, 0, 0);
    req_valid = '0;

    // R6 borrowing on resource 1: g0 borrows spare token of g1
    req_res = 4'b1111;
    wr(3, 3, 1);
    req_valid = 4'b0001;
    for (int j = 1; j <= 8; j++) begin
      if (j > 1) @(negedge clk);
      if (j == 6) req_valid = 4'b0101;
      #1;
      if (j >= 2 && j < 6) chk($sformatf("R6 borrow sample %0d", j), 32'(grant), 32'h1);
      // R7 g1 requesting keeps its own token
      if (j >= 6) chk($sformatf("R7 own token kept sample %0d", j), 32'(grant), 32'h4);
    end
    wr(3, 3, 0);
    req_valid = '0;

    // R6 borrower priority: g1 beats g2 for the spare token of g0
    wr(3, 1, 1);
    req_valid = 4'b1100;
    for (int j = 1; j <= 4; j++) begin
      if (j > 1) @(negedge clk);
      #1;
      chk($sformatf("R6 priority sample %0d", j), 32'(grant), (j == 1) ? 0 : 32'h4);
    end
    wr(3, 1, 0);
    req_valid = '0;

    // R9 over-commit after three denied cycles
    req_res = 4'b0000;
    wr(1, 0, 3);
    req_valid = 4'b1000;
    for (int j = 1; j <= 6; j++) begin
      if (j > 1) @(negedge clk);
      if (j == 5) req_valid = '0;
      #1;
      if (j >= 2) chk($sformatf("R9 irq sample %0d", j), 32'(overcommit_irq), 32'(j == 4 || j == 5));
    end

    // R8 disabled facility grants everything at once
    wr(0, 0, 0);
    req_valid = 4'hF;
    for (int j = 1; j <= 5; j++) begin
      if (j > 1) @(negedge clk);
      #1;
      chk("R8 bypass grant", 32'(grant), 32'hF);
      chk("R8 bypass irq", 32'(overcommit_irq), 0);
    end
    req_valid = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule